// File: doc/BRIEF.md
# Instruction Steering to Decoders

The block sits between instruction-boundary marking and three parallel decoders. Each clock it sees a window of up to three marked instructions in program order. For each one it gets a valid bit, a byte length, a complexity class, an unconditional-jump flag and a long-flow flag. It picks the largest in-order prefix of the window that can be decoded in one clock. It then steers that prefix onto the decoders. Decoder 0 is the only one able to expand an instruction into several micro-ops. Decoders 1 and 2 take simple instructions only. When the prefix holds one complex instruction, the group is rotated so that the complex instruction lands on decoder 0.

The block never issues more than one complex instruction per clock. It stops a group after a decoded unconditional jump and tells the fetch side to drop the rest of the window. It holds everything back while the downstream micro-op queue lacks room for the whole group.

An instruction longer than the decoders accept, or one flagged as long-flow, is handed to an internal microcode pacer. The pacer then emits that instruction's micro-op sequence at a bounded rate, limited by queue room. Issue stays blocked while the pacer is busy. The block reports the number of instructions consumed in the same cycle, and the micro-ops produced one clock later.

Top module: `decode_steer`

## Requirements
- R1: When the issued group holds only simple instructions (class 0), slot i feeds decoder i, with no rotation.
- R2: Class encoding is 0 = simple (1 micro-op), 1 = two micro-ops, 2 = three, 3 = four. When the issued group holds one complex instruction (class 1 to 3), it feeds decoder 0 and `dec0_uops` equals its micro-op count. The simple instructions of the group feed decoders 1 and 2 in program order.
- R3: The issued group is the longest valid in-order prefix of the window with at most one complex instruction. It stops before a second complex instruction, before an invalid slot, and before a non-oldest slot that needs the sequencer. `take_cnt` equals its length.
- R4: If the group's total micro-op count exceeds `q_free`, nothing is taken, `take_flush` is 0 and no decoder output follows. A count equal to `q_free` issues.
- R5: An issued jump ends the group: slots after it are not taken and `take_flush` is 1 in that cycle.
- R6: An oldest slot with length above 7 bytes or with its long-flow flag set is taken alone, with no decoder output. The pacer loads its `grp_flow` count. `take_flush` follows that slot's jump flag.
- R7: While the pacer is busy (`seq_busy`), `take_cnt` is 0. Each clock the pacer emits the least of 6, its remaining count and `q_free`, reported on `out_uops` one clock later. `seq_busy` drops once all are emitted.
- R8: `take_cnt` and `take_flush` answer the current window in the same cycle. `dec_valid`, `dec_src` (2 bits per decoder, decoder 0 in the low bits, holding the source slot index), `dec0_uops` and `out_uops` (total micro-ops from decoders or pacer) appear one clock later.
- R9: While `rst` is high, `dec_valid`, `dec_src`, `dec0_uops`, `out_uops` and `seq_busy` are 0 after the first clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| grp_valid | input | 3 | Slot holds an instruction |
| grp_len | input | 3x4 | Byte length per slot |
| grp_cls | input | 3x2 | Complexity class per slot |
| grp_jump | input | 3 | Slot is an unconditional jump |
| grp_long | input | 3 | Slot must use the microcode path |
| grp_flow | input | 3x6 | Micro-op count for the microcode path per slot |
| q_free | input | 3 | Free micro-op slots downstream (0 to 6) |
| take_cnt | output | 2 | Instructions consumed this cycle |
| take_flush | output | 1 | Drop the rest of the window (jump taken) |
| dec_valid | output | 3 | Decoder i has work |
| dec_src | output | 3x2 | Source slot index per decoder |
| dec0_uops | output | 3 | Micro-ops produced by decoder 0 |
| out_uops | output | 3 | Micro-ops produced in total |
| seq_busy | output | 1 | Microcode pacer holds remaining micro-ops |

## Verification
Consumption (`take_cnt`, `take_flush`) is combinational. It is sampled 1 ns after the window is driven at a falling edge, in the same cycle. The decoder map, `dec0_uops` and `out_uops` pass through one register. They are sampled at the next falling edge, after the rising edge that captures them. For the pacer, a handoff loads the count at the first rising edge. Each emission then appears on `out_uops` at the falling edge one clock after the pacer state that produced it, so every pacer check moves forward one falling edge per expected batch.

// File: rtl/ds_pkg.sv
package ds_pkg;
    localparam int unsigned NDEC    = 3;
    localparam int unsigned IDX_W   = 2;
    localparam int unsigned UOP_W   = 3;
    localparam int unsigned SUM_W   = 4;
    localparam int unsigned LEN_W   = 4;
    localparam int unsigned MAX_LEN = 7;
    localparam int unsigned FLOW_W  = 6;
    localparam int unsigned QCAP    = 6;
    localparam int unsigned CNT_W   = $clog2(QCAP + 1);

    typedef enum logic [1:0] {
        CL_SIMPLE = 2'd0,
        CL_CX2    = 2'd1,
        CL_CX3    = 2'd2,
        CL_CX4    = 2'd3
    } iclass_e;

    typedef struct packed {
        logic             valid;
        logic             cplx;
        logic             ucode;
        logic             jump;
        logic [UOP_W-1:0] uops;
    } slot_info_t;

    function automatic logic [UOP_W-1:0] class_uops(iclass_e c);
        return UOP_W'(c) + UOP_W'(1);
    endfunction
endpackage

// File: rtl/ds_slot_class.sv
module ds_slot_class
    import ds_pkg::*;
#(
    parameter int unsigned SLEN_W = LEN_W,
    parameter int unsigned SMAX   = MAX_LEN
) (
    input  logic              valid,
    input  logic [SLEN_W-1:0] len,
    input  logic [1:0]        cls,
    input  logic              jump,
    input  logic              lng,
    output slot_info_t        info
);
    iclass_e c;

    always_comb begin
        c          = iclass_e'(cls);
        info.valid = valid;
        info.cplx  = (c != CL_SIMPLE);
        info.ucode = lng | (len > SLEN_W'(SMAX));
        info.jump  = jump;
        info.uops  = class_uops(c);
    end
endmodule

// File: rtl/ds_group_pick.sv
module ds_group_pick
    import ds_pkg::*;
#(
    parameter int unsigned PCNT_W = CNT_W
) (
    input  logic                       clk,
    input  logic                       rst,
    input  slot_info_t                 info [NDEC],
    input  logic                       busy,
    input  logic [PCNT_W-1:0]          q_free,
    output logic [1:0]                 take,
    output logic                       flush,
    output logic                       handoff,
    output logic [NDEC-1:0]            dv,
    output logic [NDEC-1:0][IDX_W-1:0] dsrc,
    output logic [UOP_W-1:0]           d0u,
    output logic [PCNT_W-1:0]          sum_out
);
    logic [NDEC-1:0]            sel;
    logic                       run, seen, fl, fits;
    logic [IDX_W-1:0]           cidx;
    logic [1:0]                 n, k;
    logic [SUM_W-1:0]           sum;
    logic [NDEC-1:0]            mdv;
    logic [NDEC-1:0][IDX_W-1:0] msrc;
    logic [UOP_W-1:0]           md0u;

    // in-order scan: longest prefix with at most one complex instruction
    always_comb begin
        run  = 1'b1;
        seen = 1'b0;
        fl   = 1'b0;
        cidx = '0;
        n    = '0;
        sum  = '0;
        sel  = '0;
        for (int i = 0; i < NDEC; i++) begin
            if (run && info[i].valid && !info[i].ucode && !(info[i].cplx && seen)) begin
                sel[i] = 1'b1;
                n      = n + 2'd1;
                sum    = sum + SUM_W'(info[i].uops);
                if (info[i].cplx) begin
                    seen = 1'b1;
                    cidx = IDX_W'(i);
                end
                if (info[i].jump) begin
                    run = 1'b0;
                    fl  = 1'b1;
                end
            end else begin
                run = 1'b0;
            end
        end
    end

    // rotation: complex to decoder 0, simples after it in program order
    always_comb begin
        mdv  = '0;
        msrc = '0;
        md0u = '0;
        k    = seen ? 2'd1 : 2'd0;
        if (seen) begin
            mdv[0]  = 1'b1;
            msrc[0] = cidx;
            md0u    = info[cidx].uops;
        end
        for (int i = 0; i < NDEC; i++) begin
            if (sel[i] && !info[i].cplx) begin
                mdv[k]  = 1'b1;
                msrc[k] = IDX_W'(i);
                k       = k + 2'd1;
            end
        end
        if (!seen && mdv[0]) md0u = UOP_W'(1);
    end

    always_comb begin
        fits    = (sum <= SUM_W'(q_free));
        handoff = !busy && info[0].valid && info[0].ucode;
        take    = '0;
        flush   = 1'b0;
        dv      = '0;
        dsrc    = '0;
        d0u     = '0;
        sum_out = '0;
        if (handoff) begin
            take  = 2'd1;
            flush = info[0].jump;
        end else if (!busy && fits) begin
            take    = n;
            flush   = fl;
            dv      = mdv;
            dsrc    = msrc;
            d0u     = md0u;
            sum_out = PCNT_W'(sum);
        end
    end

    // R2
    dec1_simple_chk: assert property (@(posedge clk) disable iff (rst)
        dv[1] |-> !info[dsrc[1]].cplx);
    // R2
    dec2_simple_chk: assert property (@(posedge clk) disable iff (rst)
        dv[2] |-> !info[dsrc[2]].cplx);
    // R3
    two_cplx_chk: assert property (@(posedge clk) disable iff (rst)
        (info[0].cplx && info[1].cplx && !info[0].ucode) |-> take <= 2'd1);
    // R4
    room_chk: assert property (@(posedge clk) disable iff (rst)
        (|dv) |-> sum_out <= q_free);
endmodule

// File: rtl/ds_ucode_pacer.sv
module ds_ucode_pacer
    import ds_pkg::*;
#(
    parameter int unsigned RFLOW_W = FLOW_W,
    parameter int unsigned RATE    = QCAP,
    parameter int unsigned RCNT_W  = CNT_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               load,
    input  logic [RFLOW_W-1:0] load_len,
    input  logic [RCNT_W-1:0]  q_free,
    output logic               busy,
    output logic [RCNT_W-1:0]  emit
);
    logic [RFLOW_W-1:0] remaining;
    logic [RFLOW_W-1:0] e;

    always_comb begin
        e = remaining;
        if (e > RFLOW_W'(RATE))   e = RFLOW_W'(RATE);
        if (e > RFLOW_W'(q_free)) e = RFLOW_W'(q_free);
        emit = RCNT_W'(e);
        busy = (remaining != '0);
    end

    always_ff @(posedge clk) begin
        if (rst)       remaining <= '0;
        else if (load) remaining <= load_len;
        else if (busy) remaining <= remaining - e;
    end

    // R7
    pacer_progress_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && !load && q_free != '0) |=> remaining < $past(remaining));
    // R7
    pacer_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && q_free == '0) |=> $stable(remaining));
endmodule

// File: rtl/decode_steer.sv
module decode_steer
    import ds_pkg::*;
#(
    parameter int unsigned P_LEN_W   = LEN_W,
    parameter int unsigned P_MAX_LEN = MAX_LEN,
    parameter int unsigned P_FLOW_W  = FLOW_W,
    parameter int unsigned P_RATE    = QCAP,
    localparam int unsigned L_CNT_W  = CNT_W
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [NDEC-1:0]               grp_valid,
    input  logic [NDEC-1:0][P_LEN_W-1:0]  grp_len,
    input  logic [NDEC-1:0][1:0]          grp_cls,
    input  logic [NDEC-1:0]               grp_jump,
    input  logic [NDEC-1:0]               grp_long,
    input  logic [NDEC-1:0][P_FLOW_W-1:0] grp_flow,
    input  logic [L_CNT_W-1:0]            q_free,
    output logic [1:0]                    take_cnt,
    output logic                          take_flush,
    output logic [NDEC-1:0]               dec_valid,
    output logic [NDEC-1:0][IDX_W-1:0]    dec_src,
    output logic [UOP_W-1:0]              dec0_uops,
    output logic [L_CNT_W-1:0]            out_uops,
    output logic                          seq_busy
);
    slot_info_t                 info [NDEC];
    logic                       handoff;
    logic [NDEC-1:0]            p_dv;
    logic [NDEC-1:0][IDX_W-1:0] p_src;
    logic [UOP_W-1:0]           p_d0u;
    logic [L_CNT_W-1:0]         p_sum;
    logic [L_CNT_W-1:0]         emit;

    for (genvar g = 0; g < NDEC; g++) begin : g_slot
        ds_slot_class #(.SLEN_W(P_LEN_W), .SMAX(P_MAX_LEN)) u_cls (
            .valid (grp_valid[g]),
            .len   (grp_len[g]),
            .cls   (grp_cls[g]),
            .jump  (grp_jump[g]),
            .lng   (grp_long[g]),
            .info  (info[g])
        );
    end

    ds_group_pick #(.PCNT_W(L_CNT_W)) u_pick (
        .clk     (clk),
        .rst     (rst),
        .info    (info),
        .busy    (seq_busy),
        .q_free  (q_free),
        .take    (take_cnt),
        .flush   (take_flush),
        .handoff (handoff),
        .dv      (p_dv),
        .dsrc    (p_src),
        .d0u     (p_d0u),
        .sum_out (p_sum)
    );

    ds_ucode_pacer #(.RFLOW_W(P_FLOW_W), .RATE(P_RATE), .RCNT_W(L_CNT_W)) u_pacer (
        .clk      (clk),
        .rst      (rst),
        .load     (handoff),
        .load_len (grp_flow[0]),
        .q_free   (q_free),
        .busy     (seq_busy),
        .emit     (emit)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            dec_valid <= '0;
            dec_src   <= '0;
            dec0_uops <= '0;
            out_uops  <= '0;
        end else begin
            dec_valid <= p_dv;
            dec_src   <= p_src;
            dec0_uops <= p_d0u;
            out_uops  <= seq_busy ? emit : p_sum;
        end
    end

    // R7
    busy_block_chk: assert property (@(posedge clk) disable iff (rst)
        seq_busy |-> take_cnt == 2'd0);
    // R4
    out_room_chk: assert property (@(posedge clk) disable iff (rst)
        out_uops <= $past(q_free));
    // R8
    issue_count_chk: assert property (@(posedge clk) disable iff (rst)
        (|dec_valid) |-> $countones(dec_valid) == int'($past(take_cnt)));
    // R6
    handoff_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        handoff |=> dec_valid == '0);
endmodule

// File: tb/decode_steer_bench.sv
module decode_steer_bench;
    typedef struct packed {
        logic       v;
        logic       lng;
        logic       jmp;
        logic [1:0] cls;
        logic [3:0] len;
    } slot_t;

    typedef struct packed {
        slot_t      s0;
        slot_t      s1;
        slot_t      s2;
        logic [2:0] free;
        logic [1:0] take;
        logic       flush;
        logic [2:0] dv;
        logic [5:0] src;
        logic [2:0] d0u;
        logic [2:0] uops;
    } vec_t;

    function automatic slot_t sl(logic v, logic lng, logic jmp, logic [1:0] cls, logic [3:0] len);
        return '{v, lng, jmp, cls, len};
    endfunction

    localparam int NV = 17;
    localparam vec_t TBL [NV] = '{
        // R1 all simple
        '{sl(1,0,0,0,3), sl(1,0,0,0,2), sl(1,0,0,0,1), 3'd6, 2'd3, 1'b0, 3'b111, {2'd2,2'd1,2'd0}, 3'd1, 3'd3},
        // R2 S C4 S rotated
        '{sl(1,0,0,0,3), sl(1,0,0,3,5), sl(1,0,0,0,1), 3'd6, 2'd3, 1'b0, 3'b111, {2'd2,2'd0,2'd1}, 3'd4, 3'd6},
        // R2 C3 S S
        '{sl(1,0,0,2,4), sl(1,0,0,0,2), sl(1,0,0,0,2), 3'd6, 2'd3, 1'b0, 3'b111, {2'd2,2'd1,2'd0}, 3'd3, 3'd5},
        // R3 C2 C2 S serialize
        '{sl(1,0,0,1,4), sl(1,0,0,1,4), sl(1,0,0,0,2), 3'd6, 2'd1, 1'b0, 3'b001, {2'd0,2'd0,2'd0}, 3'd2, 3'd2},
        // R3 S C2 C3
        '{sl(1,0,0,0,2), sl(1,0,0,1,4), sl(1,0,0,2,4), 3'd6, 2'd2, 1'b0, 3'b011, {2'd0,2'd0,2'd1}, 3'd2, 3'd3},
        // R2 S S C4
        '{sl(1,0,0,0,2), sl(1,0,0,0,2), sl(1,0,0,3,6), 3'd6, 2'd3, 1'b0, 3'b111, {2'd1,2'd0,2'd2}, 3'd4, 3'd6},
        // R4 stall 6 > 5
        '{sl(1,0,0,0,3), sl(1,0,0,3,5), sl(1,0,0,0,1), 3'd5, 2'd0, 1'b0, 3'b000, 6'd0, 3'd0, 3'd0},
        // R4 exact fit
        '{sl(1,0,0,0,3), sl(1,0,0,0,2), sl(1,0,0,0,1), 3'd3, 2'd3, 1'b0, 3'b111, {2'd2,2'd1,2'd0}, 3'd1, 3'd3},
        // R4 stall 3 > 2
        '{sl(1,0,0,0,3), sl(1,0,0,0,2), sl(1,0,0,0,1), 3'd2, 2'd0, 1'b0, 3'b000, 6'd0, 3'd0, 3'd0},
        // R5 jump ends group
        '{sl(1,0,0,0,3), sl(1,0,1,0,2), sl(1,0,0,0,1), 3'd6, 2'd2, 1'b1, 3'b011, {2'd0,2'd1,2'd0}, 3'd1, 3'd2},
        // R5 R4 jump group stalled, no flush
        '{sl(1,0,0,0,3), sl(1,0,1,0,2), sl(1,0,0,0,1), 3'd1, 2'd0, 1'b0, 3'b000, 6'd0, 3'd0, 3'd0},
        // R6 slot1 length 8 ends group
        '{sl(1,0,0,0,3), sl(1,0,0,0,8), sl(1,0,0,0,1), 3'd6, 2'd1, 1'b0, 3'b001, 6'd0, 3'd1, 3'd1},
        // R6 length 7 accepted
        '{sl(1,0,0,0,3), sl(1,0,0,0,7), sl(1,0,0,0,1), 3'd6, 2'd3, 1'b0, 3'b111, {2'd2,2'd1,2'd0}, 3'd1, 3'd3},
        // R3 only slot0 valid
        '{sl(1,0,0,0,3), sl(0,0,0,3,2), sl(1,0,0,0,1), 3'd6, 2'd1, 1'b0, 3'b001, 6'd0, 3'd1, 3'd1},
        // R3 empty window
        '{sl(0,0,0,0,3), sl(0,0,0,0,2), sl(0,0,0,0,1), 3'd6, 2'd0, 1'b0, 3'b000, 6'd0, 3'd0, 3'd0},
        // R3 C4 S C2
        '{sl(1,0,0,3,6), sl(1,0,0,0,2), sl(1,0,0,1,3), 3'd6, 2'd2, 1'b0, 3'b011, {2'd0,2'd1,2'd0}, 3'd4, 3'd5},
        // R6 oldest length 9 handed off alone, flow 0
        '{sl(1,0,0,0,9), sl(1,0,0,0,2), sl(1,0,0,0,1), 3'd6, 2'd1, 1'b0, 3'b000, 6'd0, 3'd0, 3'd0}
    };

    logic             clk = 1'b0;
    logic             rst;
    logic [2:0]       grp_valid, grp_jump, grp_long;
    logic [2:0][3:0]  grp_len;
    logic [2:0][1:0]  grp_cls;
    logic [2:0][5:0]  grp_flow;
    logic [2:0]       q_free;
    logic [1:0]       take_cnt;
    logic             take_flush;
    logic [2:0]       dec_valid;
    logic [2:0][1:0]  dec_src;
    logic [2:0]       dec0_uops, out_uops;
    logic             seq_busy;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    decode_steer u_decode_steer (
        .clk(clk), .rst(rst), .grp_valid(grp_valid), .grp_len(grp_len),
        .grp_cls(grp_cls), .grp_jump(grp_jump), .grp_long(grp_long),
        .grp_flow(grp_flow), .q_free(q_free), .take_cnt(take_cnt),
        .take_flush(take_flush), .dec_valid(dec_valid), .dec_src(dec_src),
        .dec0_uops(dec0_uops), .out_uops(out_uops), .seq_busy(seq_busy)
    );

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic put_slot(int i, slot_t s);
        grp_valid[i] = s.v;
        grp_long[i]  = s.lng;
        grp_jump[i]  = s.jmp;
        grp_cls[i]   = s.cls;
        grp_len[i]   = s.len;
    endtask

    task automatic put_group(slot_t a, slot_t b, slot_t c, logic [2:0] fr);
        put_slot(0, a);
        put_slot(1, b);
        put_slot(2, c);
        q_free = fr;
    endtask

    initial begin
        #(200000 * 4);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        rst = 1'b1;
        grp_flow = '0;
        put_group(sl(1,0,0,0,3), sl(1,0,0,0,2), sl(1,0,0,0,1), 3'd6);
        repeat (3) @(negedge clk);
        // R9 reset state
        chk("R9", "dec_valid", int'(dec_valid), 0);
        chk("R9", "dec_src", int'(dec_src), 0);
        chk("R9", "dec0_uops", int'(dec0_uops), 0);
        chk("R9", "out_uops", int'(out_uops), 0);
        chk("R9", "seq_busy", int'(seq_busy), 0);
        rst = 1'b0;

        // R8 table walk: consumption same cycle, decoder map one clock later
        for (int v = 0; v < NV; v++) begin
            put_group(TBL[v].s0, TBL[v].s1, TBL[v].s2, TBL[v].free);
            #1;
            chk("R8", $sformatf("vec%0d take_cnt", v), int'(take_cnt), int'(TBL[v].take));
            chk("R5", $sformatf("vec%0d take_flush", v), int'(take_flush), int'(TBL[v].flush));
            @(negedge clk);
            chk("R1", $sformatf("vec%0d dec_valid", v), int'(dec_valid), int'(TBL[v].dv));
            chk("R2", $sformatf("vec%0d dec_src", v), int'(dec_src), int'(TBL[v].src));
            chk("R2", $sformatf("vec%0d dec0_uops", v), int'(dec0_uops), int'(TBL[v].d0u));
            chk("R4", $sformatf("vec%0d out_uops", v), int'(out_uops), int'(TBL[v].uops));
        end

        // R6 R7 long-flow handoff of 14 micro-ops at full room
        grp_flow[0] = 6'd14;
        put_group(sl(1,1,0,0,3), sl(1,0,0,0,2), sl(1,0,0,0,1), 3'd6);
        #1;
        chk("R6", "handoff take_cnt", int'(take_cnt), 1);
        @(negedge clk);
        grp_flow[0] = 6'd0;
        put_group(sl(1,0,0,0,3), sl(1,0,0,0,2), sl(1,0,0,0,1), 3'd6);
        #1;
        chk("R6", "handoff dec_valid", int'(dec_valid), 0);
        chk("R6", "handoff out_uops", int'(out_uops), 0);
        chk("R7", "busy after handoff", int'(seq_busy), 1);
        chk("R7", "take blocked", int'(take_cnt), 0);
        @(negedge clk);
        chk("R7", "batch1", int'(out_uops), 6);
        chk("R7", "busy batch1", int'(seq_busy), 1);
        @(negedge clk);
        chk("R7", "batch2", int'(out_uops), 6);
        chk("R7", "busy batch2", int'(seq_busy), 1);
        @(negedge clk);
        #1;
        chk("R7", "batch3", int'(out_uops), 2);
        chk("R7", "idle after", int'(seq_busy), 0);
        chk("R7", "take resumes", int'(take_cnt), 3);

        // R7 room-limited pacing, jump flag on the handed-off slot
        @(negedge clk);
        grp_flow[0] = 6'd5;
        put_group(sl(1,1,1,0,3), sl(1,0,0,0,2), sl(1,0,0,0,1), 3'd6);
        #1;
        chk("R6", "long jump take_cnt", int'(take_cnt), 1);
        chk("R6", "long jump flush", int'(take_flush), 1);
        @(negedge clk);
        grp_flow[0] = 6'd0;
        put_group(sl(0,0,0,0,3), sl(0,0,0,0,2), sl(0,0,0,0,1), 3'd0);
        @(negedge clk);
        chk("R7", "zero room emits none", int'(out_uops), 0);
        chk("R7", "zero room busy", int'(seq_busy), 1);
        q_free = 3'd3;
        @(negedge clk);
        chk("R7", "room3 batch", int'(out_uops), 3);
        @(negedge clk);
        chk("R7", "room3 tail", int'(out_uops), 2);
        chk("R7", "room3 idle", int'(seq_busy), 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule